// File: doc/BRIEF.md
# Ethernet Receive Frame Qualifier

The qualifier sits between a byte-wide receive MAC datapath and the write port of the receive FIFO. Bytes arrive after preamble and start delimiter have been removed. A start strobe marks the first destination-address byte and an end strobe marks the last FCS byte. Each byte goes to the FIFO one cycle later with its own address. The block runs a CRC-32 over every byte of the frame. When pad stripping is on, it uses the length/type field to stop writing once the real payload ends.

The FIFO exposes only the region below a committed boundary to the reader. At the end of a frame the qualifier either commits the frame, which moves that boundary past the frame's last written byte, or discards it. A discard winds the write pointer back to the committed boundary, so the host never sees the frame. Frames that collided early are discarded. Runts in half duplex are also discarded unless runt acceptance is on. This works the same way when a discarded frame follows frames that were already committed. A CRC error flag and a short-frame flag go out with each commit.

Top module: `rx_frame_qualifier`

## Requirements
- R1: After reset, fifo_we_o, commit_o, discard_o, crc_err_o and runt_o are 0, and commit_ptr_o and fifo_waddr_o are 0.
- R2: The 16-bit length/type field is byte 12 (high) and byte 13 (low), where byte 0 is the byte carrying the start strobe. A frame whose field value is above 46 is written whole, FCS included, at consecutive addresses, whatever the stripping setting.
- R3: With pad stripping on and a field value L of 46 or less, only bytes 0 to 13+L are written. Pad and FCS bytes are not written.
- R4: With pad stripping off, every byte of the frame is written, even when L is 46 or less.
- R5: The CRC covers all received bytes, pad included: reflected polynomial 0x04C11DB7, register initialised to all ones. A correct frame leaves the right-shifting register at 0xDEBB20E3, which is the bit reversal of 0xC704DD7B. On commit, crc_err_o is 1 if and only if that residue is not reached.
- R6: commit_o or discard_o pulses in the cycle after the end-strobe byte is accepted. commit_ptr_o changes only on a commit, and then moves to the address just past the frame's last written byte.
- R7: A collision seen while fewer than 64 bytes of the frame have been received deletes the frame: discard_o pulses and commit_ptr_o stays unchanged.
- R8: A collision seen at byte index 64 or later does not delete the frame.
- R9: A frame of fewer than 64 bytes, FCS included, is discarded when full_duplex_i and runt_accept_i are both 0.
- R10: A frame of fewer than 64 bytes is committed with runt_o = 1 when full_duplex_i or runt_accept_i is 1.
- R11: After a discard that follows committed frames, the next frame is written starting at the current commit_ptr_o, and earlier committed data is not disturbed.
- R12: Each end-strobe byte produces exactly one of commit_o and discard_o, never both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Byte valid |
| rx_data_i | input | 8 | Received byte |
| rx_sof_i | input | 1 | First byte of frame (with valid) |
| rx_eof_i | input | 1 | Last byte of frame (with valid) |
| col_i | input | 1 | Collision indication |
| full_duplex_i | input | 1 | Full-duplex mode |
| pad_strip_en_i | input | 1 | Enable pad stripping |
| runt_accept_i | input | 1 | Accept short frames |
| fifo_wdata_o | output | 8 | FIFO write data |
| fifo_waddr_o | output | ADDR_W | FIFO write address |
| fifo_we_o | output | 1 | FIFO write enable |
| commit_o | output | 1 | Frame committed |
| discard_o | output | 1 | Frame discarded and write pointer rewound |
| commit_ptr_o | output | ADDR_W | Committed (readable) boundary |
| crc_err_o | output | 1 | CRC mismatch of last ended frame |
| runt_o | output | 1 | Last ended frame shorter than 64 bytes |

## Verification
A byte accepted at a rising edge appears on the FIFO write port after that edge. Commit or discard, the status flags and the new commit boundary all appear one edge after the end-strobe byte. The bench drives inputs and records the write port on the falling edge, half a cycle clear of the registers. It tests the frame outcome at the first falling edge after the end byte's edge. Deletion and rewind are seen at the ports: a discarded frame leaves the commit boundary unchanged, and the next good frame must land exactly on that boundary with earlier contents intact.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned MIN_FRAME_BYTES = 64;
  localparam int unsigned LEN_FIELD_MAX   = 46;
  localparam int unsigned HDR_BYTES       = 14;
  localparam int unsigned LT_HI_IDX       = 12;
  localparam int unsigned LT_LO_IDX       = 13;
  localparam logic [31:0] CRC_INIT        = 32'hFFFF_FFFF;
  localparam logic [31:0] CRC_POLY_REFL   = 32'hEDB8_8320;
  localparam logic [31:0] CRC_RESIDUE     = 32'hDEBB_20E3;

  function automatic logic [31:0] crc32_byte(input logic [31:0] crc, input logic [7:0] b);
    logic [31:0] c;
    c = crc ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction
endpackage

// File: rtl/rxq_crc32.sv
module rxq_crc32
  import rxq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        byte_ev_i,
  input  logic        start_i,
  input  logic [7:0]  data_i,
  output logic        match_o
);
  logic [31:0] crc_q, crc_d;

  assign crc_d   = crc32_byte(start_i ? CRC_INIT : crc_q, data_i);
  assign match_o = (crc_d == CRC_RESIDUE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        crc_q <= CRC_INIT;
    else if (byte_ev_i) crc_q <= crc_d;
  end
endmodule

// File: rtl/rxq_frame_ctl.sv
module rxq_frame_ctl
  import rxq_pkg::*;
#(
  parameter int unsigned CNT_W = 11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_sof_i,
  input  logic       rx_eof_i,
  input  logic       col_i,
  input  logic       full_duplex_i,
  input  logic       pad_strip_en_i,
  input  logic       runt_accept_i,
  input  logic       crc_match_i,
  output logic       byte_ev_o,
  output logic       sof_ev_o,
  output logic       keep_o,
  output logic       commit_ev_o,
  output logic       discard_ev_o,
  output logic       commit_o,
  output logic       discard_o,
  output logic       crc_err_o,
  output logic       runt_o
);
  localparam logic [CNT_W-1:0] MIN_L   = CNT_W'(MIN_FRAME_BYTES);
  localparam logic [CNT_W-1:0] SHORT_L = CNT_W'(MIN_FRAME_BYTES - 1);
  localparam logic [CNT_W-1:0] HDR_L   = CNT_W'(HDR_BYTES);
  localparam logic [CNT_W-1:0] LTHI_L  = CNT_W'(LT_HI_IDX);
  localparam logic [CNT_W-1:0] LTLO_L  = CNT_W'(LT_LO_IDX);
  localparam logic [15:0]      LMAX_L  = 16'(LEN_FIELD_MAX);

  logic             active_q, col_flag_q, strip_q;
  logic [CNT_W-1:0] cnt_q, idx, win_idx, keep_lim_q;
  logic [7:0]       lt_hi_q;
  logic [15:0]      lt_val;
  logic             col_now, collided, stripped, short_fr, drop, end_ev;

  assign sof_ev_o  = rx_valid_i && rx_sof_i;
  assign byte_ev_o = rx_valid_i && (rx_sof_i || active_q);
  assign idx       = rx_sof_i ? '0 : cnt_q;
  assign win_idx   = byte_ev_o ? idx : cnt_q;
  assign lt_val    = {lt_hi_q, rx_data_i};

  // early-collision window counted in byte times from frame start
  assign col_now  = col_i && (active_q || sof_ev_o) && (win_idx < MIN_L);
  assign collided = col_now || (col_flag_q && !sof_ev_o);
  assign stripped = strip_q && (idx >= HDR_L) && (idx >= keep_lim_q);
  assign keep_o   = byte_ev_o && !collided && !stripped;

  assign end_ev       = byte_ev_o && rx_eof_i;
  assign short_fr     = idx < SHORT_L;
  assign drop         = collided || (short_fr && !full_duplex_i && !runt_accept_i);
  assign commit_ev_o  = end_ev && !drop;
  assign discard_ev_o = end_ev && drop;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      cnt_q      <= '0;
      col_flag_q <= 1'b0;
      strip_q    <= 1'b0;
      keep_lim_q <= '0;
      lt_hi_q    <= '0;
      commit_o   <= 1'b0;
      discard_o  <= 1'b0;
      crc_err_o  <= 1'b0;
      runt_o     <= 1'b0;
    end else begin
      commit_o  <= commit_ev_o;
      discard_o <= discard_ev_o;
      if (byte_ev_o) begin
        active_q   <= !rx_eof_i;
        cnt_q      <= (idx == '1) ? idx : idx + CNT_W'(1);
        col_flag_q <= collided;
        if (rx_sof_i) strip_q <= 1'b0;
        if (idx == LTHI_L) lt_hi_q <= rx_data_i;
        if (idx == LTLO_L) begin
          strip_q    <= pad_strip_en_i && (lt_val <= LMAX_L);
          keep_lim_q <= HDR_L + CNT_W'(lt_val[5:0]);
        end
      end else if (col_now) begin
        col_flag_q <= 1'b1;
      end
      if (end_ev) begin
        crc_err_o <= !crc_match_i;
        runt_o    <= short_fr;
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit_o && discard_o)); // R12
  AST_RUNT_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_ev && short_fr && !full_duplex_i && !runt_accept_i) |=> discard_o); // R9
  AST_LATE_COL_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_ev && !col_flag_q && !col_now && !short_fr) |=> commit_o); // R8
endmodule

// File: rtl/rxq_wptr.sv
module rxq_wptr #(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_ev_i,
  input  logic              sof_ev_i,
  input  logic              keep_i,
  input  logic              commit_ev_i,
  input  logic              discard_ev_i,
  input  logic [7:0]        data_i,
  output logic              we_o,
  output logic [7:0]        wdata_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W-1:0] cptr_o
);
  logic [ADDR_W-1:0] wptr_q, cptr_q, base, next_ptr;

  // a new frame always restarts from the committed boundary
  assign base     = sof_ev_i ? cptr_q : wptr_q;
  assign next_ptr = base + ADDR_W'(keep_i);
  assign cptr_o   = cptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      cptr_q  <= '0;
      we_o    <= 1'b0;
      wdata_o <= '0;
      waddr_o <= '0;
    end else begin
      we_o <= keep_i;
      if (keep_i) begin
        wdata_o <= data_i;
        waddr_o <= base;
      end
      if (discard_ev_i)   wptr_q <= cptr_q;
      else if (byte_ev_i) wptr_q <= next_ptr;
      if (commit_ev_i)    cptr_q <= next_ptr;
    end
  end

  AST_REWIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    discard_ev_i |=> (wptr_q == cptr_q)); // R7
  AST_CPTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_ev_i |=> $stable(cptr_q)); // R6
endmodule

// File: rtl/rx_frame_qualifier.sv
module rx_frame_qualifier #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned CNT_W  = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [7:0]        rx_data_i,
  input  logic              rx_sof_i,
  input  logic              rx_eof_i,
  input  logic              col_i,
  input  logic              full_duplex_i,
  input  logic              pad_strip_en_i,
  input  logic              runt_accept_i,
  output logic [7:0]        fifo_wdata_o,
  output logic [ADDR_W-1:0] fifo_waddr_o,
  output logic              fifo_we_o,
  output logic              commit_o,
  output logic              discard_o,
  output logic [ADDR_W-1:0] commit_ptr_o,
  output logic              crc_err_o,
  output logic              runt_o
);
  logic byte_ev, sof_ev, keep, commit_ev, discard_ev, crc_match;

  rxq_crc32 u_crc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .byte_ev_i (byte_ev),
    .start_i   (rx_sof_i),
    .data_i    (rx_data_i),
    .match_o   (crc_match)
  );

  rxq_frame_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rx_valid_i     (rx_valid_i),
    .rx_data_i      (rx_data_i),
    .rx_sof_i       (rx_sof_i),
    .rx_eof_i       (rx_eof_i),
    .col_i          (col_i),
    .full_duplex_i  (full_duplex_i),
    .pad_strip_en_i (pad_strip_en_i),
    .runt_accept_i  (runt_accept_i),
    .crc_match_i    (crc_match),
    .byte_ev_o      (byte_ev),
    .sof_ev_o       (sof_ev),
    .keep_o         (keep),
    .commit_ev_o    (commit_ev),
    .discard_ev_o   (discard_ev),
    .commit_o       (commit_o),
    .discard_o      (discard_o),
    .crc_err_o      (crc_err_o),
    .runt_o         (runt_o)
  );

  rxq_wptr #(.ADDR_W(ADDR_W)) u_wptr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_ev_i    (byte_ev),
    .sof_ev_i     (sof_ev),
    .keep_i       (keep),
    .commit_ev_i  (commit_ev),
    .discard_ev_i (discard_ev),
    .data_i       (rx_data_i),
    .we_o         (fifo_we_o),
    .wdata_o      (fifo_wdata_o),
    .waddr_o      (fifo_waddr_o),
    .cptr_o       (commit_ptr_o)
  );
endmodule

// File: tb/rx_frame_qualifier_tb.sv
module rx_frame_qualifier_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, col = 1'b0;
  logic [7:0] rx_data = '0;
  logic       fd = 1'b0, strip = 1'b0, ra = 1'b0;
  logic [7:0] fifo_wdata;
  logic [9:0] fifo_waddr, commit_ptr;
  logic       fifo_we, commit, discard, crc_err, runt;

  int n_checks = 0, n_fail = 0;
  int wr_cnt = 0, n_commit = 0, n_discard = 0;
  logic [7:0] mem [0:1023];
  logic [7:0] frm [0:127];
  int frm_n;
  int exp_cptr = 0;

  always #4 clk = ~clk;

  rx_frame_qualifier u_dut (
    .clk_i(clk), .rst_ni(rst_n), .rx_valid_i(rx_valid), .rx_data_i(rx_data),
    .rx_sof_i(rx_sof), .rx_eof_i(rx_eof), .col_i(col), .full_duplex_i(fd),
    .pad_strip_en_i(strip), .runt_accept_i(ra), .fifo_wdata_o(fifo_wdata),
    .fifo_waddr_o(fifo_waddr), .fifo_we_o(fifo_we), .commit_o(commit),
    .discard_o(discard), .commit_ptr_o(commit_ptr), .crc_err_o(crc_err), .runt_o(runt)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (fifo_we) begin
        mem[fifo_waddr] = fifo_wdata;
        wr_cnt++;
      end
      if (commit) n_commit++;
      if (discard) n_discard++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] fcs_of(input int n);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < n; i++) begin
      c ^= {24'd0, frm[i]};
      for (int k = 0; k < 8; k++) c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
    end
    return ~c;
  endfunction

  task automatic build(input int nd, input logic [15:0] lt, input int corrupt);
    logic [31:0] f;
    for (int i = 0; i < nd; i++) frm[i] = (i < 12) ? 8'(i + 16) : 8'(i * 7 + 3);
    frm[12] = lt[15:8];
    frm[13] = lt[7:0];
    f = fcs_of(nd);
    for (int i = 0; i < 4; i++) frm[nd + i] = f[8*i +: 8];
    frm_n = nd + 4;
    if (corrupt >= 0) frm[corrupt] ^= 8'h01;
  endtask

  task automatic run_frame(input int nd, input logic [15:0] lt, input int corrupt,
                           input int col_at, input logic fd_v, input logic st_v,
                           input logic ra_v, input bit exp_commit, input int exp_keep,
                           input logic exp_crc, input logic exp_runt, input string tag);
    int c0, d0, w0, start, bad;
    build(nd, lt, corrupt);
    @(negedge clk);
    fd = fd_v; strip = st_v; ra = ra_v;
    c0 = n_commit; d0 = n_discard; w0 = wr_cnt; start = exp_cptr;
    for (int i = 0; i < frm_n; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_data = frm[i];
      rx_sof = (i == 0); rx_eof = (i == frm_n - 1); col = (i == col_at);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; col = 1'b0;
    check(commit == exp_commit && discard == !exp_commit, {tag, " R6 outcome one cycle after end byte"},
          {commit, discard}, {exp_commit, !exp_commit});
    @(negedge clk);
    check((n_commit - c0) + (n_discard - d0) == 1, {tag, " R12 single outcome"},
          (n_commit - c0) + (n_discard - d0), 1);
    if (exp_commit) begin
      check(n_commit - c0 == 1, {tag, " commit"}, n_commit - c0, 1);
      check(wr_cnt - w0 == exp_keep, {tag, " bytes written"}, wr_cnt - w0, exp_keep);
      bad = 0;
      for (int i = 0; i < exp_keep; i++) if (mem[(start + i) % 1024] !== frm[i]) bad++;
      check(bad == 0, {tag, " stored contents"}, bad, 0);
      exp_cptr = (start + exp_keep) % 1024;
      check(int'(commit_ptr) == exp_cptr, {tag, " R6 commit pointer"}, commit_ptr, exp_cptr);
      check(crc_err == exp_crc, {tag, " R5 crc flag"}, crc_err, exp_crc);
      check(runt == exp_runt, {tag, " runt flag"}, runt, exp_runt);
    end else begin
      check(n_discard - d0 == 1, {tag, " discard"}, n_discard - d0, 1);
      check(int'(commit_ptr) == start, {tag, " R11 boundary held"}, commit_ptr, start);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!fifo_we && !commit && !discard && !crc_err && !runt, "R1 outputs idle",
          {fifo_we, commit, discard, crc_err, runt}, 0);
    check(commit_ptr == 0 && fifo_waddr == 0, "R1 pointers zero", commit_ptr, 0);
  endtask

  task automatic t_type_frames();
    run_frame(60, 16'h0800, -1, -1, 0, 1, 0, 1, 64, 0, 0, "R2 type frame");
    run_frame(60, 16'd47,   -1, -1, 0, 1, 0, 1, 64, 0, 0, "R2 field 47");
  endtask

  task automatic t_strip();
    run_frame(60, 16'd10, -1, -1, 0, 1, 0, 1, 24, 0, 0, "R3 len 10 stripped");
    run_frame(60, 16'd46, -1, -1, 0, 1, 0, 1, 60, 0, 0, "R3 len 46 fcs dropped");
    run_frame(60, 16'd10, -1, -1, 0, 0, 0, 1, 64, 0, 0, "R4 strip off");
  endtask

  task automatic t_crc();
    run_frame(60, 16'h0800, 63, -1, 0, 1, 0, 1, 64, 1, 0, "R5 bad fcs");
    run_frame(60, 16'd10,   40, -1, 0, 1, 0, 1, 24, 1, 0, "R5 bad pad byte");
  endtask

  task automatic t_collision();
    run_frame(60, 16'h0800, -1, 30, 0, 1, 0, 0, 0, 0, 0, "R7 col at 30");
    run_frame(60, 16'h0800, -1, 63, 0, 1, 0, 0, 0, 0, 0, "R7 col at 63");
    run_frame(60, 16'h0800, -1, -1, 0, 1, 0, 1, 64, 0, 0, "R11 frame after discards");
    run_frame(70, 16'h0800, -1, 64, 0, 1, 0, 1, 74, 0, 0, "R8 col at 64");
  endtask

  task automatic t_runt();
    run_frame(40, 16'h0800, -1, -1, 0, 1, 0, 0, 0, 0, 0, "R9 runt half duplex");
    run_frame(59, 16'h0800, -1, -1, 0, 1, 0, 0, 0, 0, 0, "R9 63 byte frame");
    run_frame(40, 16'h0800, -1, -1, 0, 1, 1, 1, 44, 0, 1, "R10 runt accepted");
    run_frame(40, 16'h0800, -1, -1, 1, 1, 0, 1, 44, 0, 1, "R10 runt full duplex");
  endtask

  initial begin
    t_reset();
    t_type_frames();
    t_strip();
    t_crc();
    t_collision();
    t_runt();
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule